// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Lookup Core

This block is the lookup and line-management core of a four-way set-associative cache. A request carries a virtual address, which selects the set and the word within the line, and a physical address from an external translation unit, whose upper bits are compared with the stored tags of all four ways at once. A read hit returns the selected 32-bit word. A miss chooses a victim way. If that way holds modified data, its eight words are streamed out. The line is then fetched from memory and installed before the response is returned.

Each line keeps a valid flag, a modified (dirty) flag and a 19-bit tag. Each set keeps six replacement bits that record the age order of every pair of ways, which gives true least-recently-used replacement. A mode pin chooses copy-back or write-through for each access. Copy-back writes only mark the line dirty. Write-through writes also forward the word to memory and never allocate on a miss.

Every data interface uses valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A source that has raised valid keeps it high, and keeps its payload unchanged, until the transfer happens. The core handles one request at a time. It raises `req_ready` only while idle, and it drives at most one of its outgoing handshakes at any moment.

Top module: `cache4_lookup`

## Requirements
- R1: After reset `req_ready` is 1, every outgoing valid is 0, and every line is invalid and clean, so the first read of any address misses.
- R2: A read hits only when the line in set `vaddr[5+IDX_W-1:5]` is valid and its tag equals `paddr[28:10]`. The response then gives `rsp_hit`=1, the hit way in `rsp_way`, and the word selected by `vaddr[4:2]`.
- R3: On a read miss the core issues one fetch with address `{paddr[28:5],5'b0}`. It then accepts exactly eight fill beats, storing beat k as word k. It responds with `rsp_hit`=0, the filled way, and the requested word. A later read of the same line hits.
- R4: When a set has invalid ways, the victim is the lowest-numbered invalid way.
- R5: When all four ways are valid, the victim is the least recently used way. Both hits and fills make a way the most recent. Replacement bit k covers way pair k in the order (0,1),(0,2),(0,3),(1,2),(1,3),(2,3), and a 1 means the lower-numbered way is newer.
- R6: A copy-back write hit replaces the selected word, sets the line dirty, answers `rsp_hit`=1 with `rsp_rdata` equal to the written data, and produces no write-through transfer.
- R7: A write-through write hit replaces the word and forwards one transfer with `wt_addr`=`{paddr[28:2],2'b0}` and the written data. It leaves the line clean, so evicting that line later produces no write-back.
- R8: A write-through write miss forwards the write, answers `rsp_hit`=0, issues no fetch and allocates no line.
- R9: A dirty victim is written back before the fetch. The core sends eight beats, words 0 to 7, with `wb_tag` and `wb_set` naming the old line and `wb_last` high only on the eighth beat.
- R10: A copy-back write miss fetches and installs the line, then writes the word and marks it dirty. A later read returns the written data as a hit.
- R11: While any valid is held against a low ready, the payload of that interface stays unchanged. At most one of `req_ready`, `rsp_valid`, `wb_valid`, `mrd_valid`, `fill_ready` and `wt_valid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| copyback | input | 1 | 1 = copy-back, 0 = write-through; sampled when a request is accepted |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Core is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual address (set and word selection) |
| req_paddr | input | 29 | Translated physical address (tag source) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | 2 | Hit way or allocated way |
| rsp_rdata | output | 32 | Read word, or written data for writes |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Write-back sink ready |
| wb_tag | output | 19 | Tag of the evicted line |
| wb_set | output | IDX_W | Set of the evicted line |
| wb_data | output | 32 | Write-back word |
| wb_last | output | 1 | Final write-back beat |
| mrd_valid | output | 1 | Line fetch request valid |
| mrd_ready | input | 1 | Memory accepts fetch |
| mrd_addr | output | 29 | Line-aligned fetch address |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Core accepts fill beats |
| fill_data | input | 32 | Fill word |
| wt_valid | output | 1 | Write-through transfer valid |
| wt_ready | input | 1 | Memory accepts write-through |
| wt_addr | output | 29 | Word-aligned write-through address |
| wt_data | output | 32 | Write-through data |

## Verification
The assertions assume that fill beats arrive only after the core has accepted a fetch, and that the mode pin matters only on the cycle a request is accepted. They also assume the consumers of responses, write-backs and write-throughs may stall for any length of time. The stimulus keeps within these limits. The memory model starts sending beats only after a fetch handshake and always sends exactly eight. The driver changes `copyback` only between requests. The ready inputs and `fill_valid` are stalled in fixed rotating patterns, so the hold properties are exercised on every interface.

// File: rtl/cache4_pkg.sv
package cache4_pkg;
  localparam int WAYS       = 4;
  localparam int LINE_WORDS = 8;
  localparam int PA_W       = 29;
  localparam int TAG_LO     = 10;
  localparam int TAG_W      = PA_W - TAG_LO;
  localparam int AGE_W      = WAYS * (WAYS - 1) / 2;

  typedef logic [1:0] way_t;

  // pair bit k covers ways (a,b), a<b, in ascending order; 1 = a is newer
  function automatic logic [AGE_W-1:0] age_touch(input logic [AGE_W-1:0] cur,
                                                 input way_t w);
    logic [AGE_W-1:0] nx;
    int k;
    nx = cur;
    k  = 0;
    for (int a = 0; a < WAYS; a++) begin
      for (int b = a + 1; b < WAYS; b++) begin
        if (a == int'(w))      nx[k] = 1'b1;
        else if (b == int'(w)) nx[k] = 1'b0;
        k++;
      end
    end
    return nx;
  endfunction

  function automatic way_t age_oldest(input logic [AGE_W-1:0] bits);
    way_t pick;
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int v = 0; v < WAYS; v++) begin
      logic older;
      int k;
      older = 1'b1;
      k     = 0;
      for (int a = 0; a < WAYS; a++) begin
        for (int b = a + 1; b < WAYS; b++) begin
          if (a == v && bits[k])  older = 1'b0;
          if (b == v && !bits[k]) older = 1'b0;
          k++;
        end
      end
      if (older && !found) begin
        pick  = way_t'(v);
        found = 1'b1;
      end
    end
    return pick;
  endfunction
endpackage

// File: rtl/cache4_tags.sv
module cache4_tags
  import cache4_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            set_idx,
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic                        fill_en,
  input  way_t                        fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        mark_en,
  input  way_t                        mark_way,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_vec
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]           tag_mem [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]  valid_q;
  logic [SETS-1:0][WAYS-1:0]  dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[set_idx][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[set_idx][fill_way] <= 1'b1;
        dirty_q[set_idx][fill_way] <= 1'b0;
      end
      if (mark_en) dirty_q[set_idx][mark_way] <= 1'b1;
    end
  end

  assign valid_vec = valid_q[set_idx];
  assign dirty_vec = dirty_q[set_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign tag_vec[w] = tag_mem[set_idx][w];
    assign hit_vec[w] = valid_q[set_idx][w] && (tag_mem[set_idx][w] == cmp_tag);
  end
endmodule

// File: rtl/cache4_age.sv
module cache4_age
  import cache4_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             touch_en,
  input  way_t             touch_way,
  output way_t             victim
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0][AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        age_q <= '0;
    else if (touch_en) age_q[set_idx] <= age_touch(age_q[set_idx], touch_way);
  end

  always_comb begin
    victim = age_oldest(age_q[set_idx]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) victim = way_t'(w);
    end
  end
endmodule

// File: rtl/cache4_data.sv
module cache4_data
  import cache4_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                          clk,
  input  logic                          we,
  input  way_t                          w_way,
  input  logic [IDX_W-1:0]              set_idx,
  input  logic [$clog2(LINE_WORDS)-1:0] w_word,
  input  logic [31:0]                   w_data,
  input  way_t                          r_way,
  input  logic [$clog2(LINE_WORDS)-1:0] r_word,
  output logic [31:0]                   r_data
);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int DEPTH  = WAYS * (1 << IDX_W) * LINE_WORDS;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{w_way, set_idx, w_word}] <= w_data;
  end

  assign r_data = mem[{r_way, set_idx, r_word}];
endmodule

// File: rtl/cache4_lookup.sv
module cache4_lookup
  import cache4_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             copyback,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [31:0]      req_vaddr,
  input  logic [28:0]      req_paddr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [1:0]       rsp_way,
  output logic [31:0]      rsp_rdata,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [18:0]      wb_tag,
  output logic [IDX_W-1:0] wb_set,
  output logic [31:0]      wb_data,
  output logic             wb_last,
  output logic             mrd_valid,
  input  logic             mrd_ready,
  output logic [28:0]      mrd_addr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [31:0]      fill_data,
  output logic             wt_valid,
  input  logic             wt_ready,
  output logic [28:0]      wt_addr,
  output logic [31:0]      wt_data
);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_LO = 2 + WORD_W;
  localparam logic [WORD_W-1:0] LAST = WORD_W'(LINE_WORDS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_MREQ, S_FILL, S_DONE, S_WT, S_RSP
  } state_t;

  state_t              state;
  logic                q_write, q_cb;
  logic [31:0]         q_va, q_wd;
  logic [PA_W-1:0]     q_pa;
  logic [WORD_W-1:0]   beat;
  way_t                vway;

  logic [IDX_W-1:0]    set_idx;
  logic [WORD_W-1:0]   word;
  logic [TAG_W-1:0]    ptag;
  logic [WAYS-1:0]     hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] tag_vec;
  logic                any_hit;
  way_t                hit_way, victim;
  logic                last_fill;

  logic                dw_en;
  way_t                dw_way, rd_way;
  logic [WORD_W-1:0]   dw_word, rd_word;
  logic [31:0]         dw_data, rd_data;

  assign set_idx   = q_va[IDX_LO +: IDX_W];
  assign word      = q_va[2 +: WORD_W];
  assign ptag      = q_pa[PA_W-1:TAG_LO];
  assign any_hit   = |hit_vec;
  assign last_fill = (state == S_FILL) && fill_valid && (beat == LAST);

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end

  cache4_tags #(.IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .cmp_tag(ptag),
    .fill_en(last_fill), .fill_way(vway), .fill_tag(ptag),
    .mark_en(((state == S_LOOK) && any_hit && q_write && q_cb) ||
             ((state == S_DONE) && q_write)),
    .mark_way((state == S_LOOK) ? hit_way : vway),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tag_vec(tag_vec)
  );

  cache4_age #(.IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .valid_vec(valid_vec),
    .touch_en(((state == S_LOOK) && any_hit) || last_fill),
    .touch_way((state == S_LOOK) ? hit_way : vway),
    .victim(victim)
  );

  always_comb begin
    dw_en   = 1'b0;
    dw_way  = vway;
    dw_word = word;
    dw_data = q_wd;
    unique case (state)
      S_LOOK: if (any_hit && q_write) begin
        dw_en  = 1'b1;
        dw_way = hit_way;
      end
      S_FILL: if (fill_valid) begin
        dw_en   = 1'b1;
        dw_word = beat;
        dw_data = fill_data;
      end
      S_DONE: dw_en = q_write;
      default: ;
    endcase
  end

  assign rd_way  = (state == S_LOOK) ? hit_way : vway;
  assign rd_word = (state == S_WB) ? beat : word;

  cache4_data #(.IDX_W(IDX_W)) u_data (
    .clk(clk), .we(dw_en), .w_way(dw_way), .set_idx(set_idx),
    .w_word(dw_word), .w_data(dw_data), .r_way(rd_way), .r_word(rd_word),
    .r_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      q_write   <= 1'b0;
      q_cb      <= 1'b0;
      q_va      <= '0;
      q_pa      <= '0;
      q_wd      <= '0;
      beat      <= '0;
      vway      <= '0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_rdata <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_cb    <= copyback;
          q_va    <= req_vaddr;
          q_pa    <= req_paddr;
          q_wd    <= req_wdata;
          state   <= S_LOOK;
        end
        S_LOOK: begin
          beat <= '0;
          if (any_hit) begin
            rsp_hit   <= 1'b1;
            rsp_way   <= hit_way;
            rsp_rdata <= q_write ? q_wd : rd_data;
            state     <= (q_write && !q_cb) ? S_WT : S_RSP;
          end else if (q_write && !q_cb) begin
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_rdata <= q_wd;
            state     <= S_WT;
          end else begin
            vway  <= victim;
            state <= (valid_vec[victim] && dirty_vec[victim]) ? S_WB : S_MREQ;
          end
        end
        S_WB: if (wb_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) state <= S_MREQ;
        end
        S_MREQ: if (mrd_ready) begin
          beat  <= '0;
          state <= S_FILL;
        end
        S_FILL: if (fill_valid) begin
          beat <= beat + 1'b1;
          if (beat == LAST) state <= S_DONE;
        end
        S_DONE: begin
          rsp_hit   <= 1'b0;
          rsp_way   <= vway;
          rsp_rdata <= q_write ? q_wd : rd_data;
          state     <= S_RSP;
        end
        S_WT:  if (wt_ready)  state <= S_RSP;
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_RSP);
  assign wb_valid   = (state == S_WB);
  assign wb_data    = rd_data;
  assign wb_last    = (beat == LAST);
  assign wb_tag     = tag_vec[vway];
  assign wb_set     = set_idx;
  assign mrd_valid  = (state == S_MREQ);
  assign mrd_addr   = {q_pa[PA_W-1:IDX_LO], {IDX_LO{1'b0}}};
  assign fill_ready = (state == S_FILL);
  assign wt_valid   = (state == S_WT);
  assign wt_addr    = {q_pa[PA_W-1:2], 2'b00};
  assign wt_data    = q_wd;
endmodule

// File: rtl/cache4_lookup_chk.sv
module cache4_lookup_chk #(
  parameter int IDX_W = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic [1:0]  rsp_way,
  input logic [31:0] rsp_rdata,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_data,
  input logic        wb_last,
  input logic        mrd_valid,
  input logic        mrd_ready,
  input logic [28:0] mrd_addr,
  input logic        fill_ready,
  input logic        wt_valid
);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
                                $stable(rsp_way) && $stable(rsp_rdata));

  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_last));

  p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_valid, wb_valid, mrd_valid, fill_ready, wt_valid}));

  p_mrd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

  p_fill_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_ready) |-> $past(mrd_valid && mrd_ready));

  p_wb_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && wb_last |=> mrd_valid);

  p_fetch_line_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |-> mrd_addr[4:0] == 5'd0);
endmodule

bind cache4_lookup cache4_lookup_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/cache4_lookup_bench.sv
`timescale 1ns/1ps
module cache4_lookup_bench;
  localparam int IDX_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic copyback, req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, req_wdata;
  logic [28:0] req_paddr;
  logic rsp_valid, rsp_ready, rsp_hit;
  logic [1:0] rsp_way;
  logic [31:0] rsp_rdata;
  logic wb_valid, wb_ready, wb_last;
  logic [18:0] wb_tag;
  logic [IDX_W-1:0] wb_set;
  logic [31:0] wb_data;
  logic mrd_valid, mrd_ready;
  logic [28:0] mrd_addr;
  logic fill_valid, fill_ready;
  logic [31:0] fill_data;
  logic wt_valid, wt_ready;
  logic [28:0] wt_addr;
  logic [31:0] wt_data;

  always #4 clk = ~clk;

  cache4_lookup #(.IDX_W(IDX_W)) u_cache4_lookup (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // external memory model
  logic [31:0] ext [logic [26:0]];
  function automatic logic [31:0] pat(input logic [26:0] a);
    return ({5'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
  endfunction
  function automatic logic [31:0] ext_rd(input logic [26:0] a);
    return ext.exists(a) ? ext[a] : pat(a);
  endfunction
  function automatic logic [28:0] pa_of(input logic [18:0] t, input int s, input int w);
    return {t, 5'(s), 3'(w), 2'b00};
  endfunction
  function automatic logic [31:0] mem_at(input logic [18:0] t, input int s, input int w);
    return ext_rd({t, 5'(s), 3'(w)});
  endfunction

  // scoreboard
  typedef struct { logic hit; logic [1:0] way; logic [31:0] data; string rq; } exp_t;
  exp_t sb[$];

  // responder state
  int cyc = 0, n_mrd = 0, n_wt = 0, wb_beats = 0, wb_at_mrd = 0;
  int fill_idx = 0;
  bit fill_act = 1'b0, wb_last_ok = 1'b1;
  logic [23:0] fill_line;
  logic [2:0] wb_idx = '0;
  logic [31:0] wb_buf [8];
  logic [18:0] wb_tag_seen;
  logic [IDX_W-1:0] wb_set_seen;
  logic [28:0] last_mrd_addr, last_wt_addr;
  logic [31:0] last_wt_data;

  initial begin
    wb_ready = 1'b0; mrd_ready = 1'b0; fill_valid = 1'b0; fill_data = '0; wt_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      wb_ready = (cyc % 3) != 0;
      if (rst_n && wb_valid && wb_ready) begin
        wb_buf[wb_idx] = wb_data;
        if (wb_last != (wb_idx == 3'd7)) wb_last_ok = 1'b0;
        wb_tag_seen = wb_tag;
        wb_set_seen = wb_set;
        ext[{wb_tag, wb_set[4:0], wb_idx}] = wb_data;
        wb_idx++;
        wb_beats++;
      end
      mrd_ready = mrd_valid && ((cyc % 2) == 0);
      if (rst_n && mrd_valid && mrd_ready) begin
        n_mrd++;
        last_mrd_addr = mrd_addr;
        fill_line = mrd_addr[28:5];
        fill_idx = 0;
        fill_act = 1'b1;
        wb_at_mrd = wb_beats;
      end
      if (fill_act) begin
        fill_valid = (cyc % 4) != 3;
        fill_data = ext_rd({fill_line, 3'(fill_idx)});
        if (fill_valid && fill_ready) begin
          fill_idx++;
          if (fill_idx == 8) fill_act = 1'b0;
        end
      end else fill_valid = 1'b0;
      wt_ready = (cyc % 3) != 2;
      if (rst_n && wt_valid && wt_ready) begin
        n_wt++;
        last_wt_addr = wt_addr;
        last_wt_data = wt_data;
        ext[wt_addr[28:2]] = wt_data;
      end
    end
  end

  // response monitor
  initial begin
    int mc = 0;
    bit held = 1'b0;
    logic h_hit;
    logic [1:0] h_way;
    logic [31:0] h_data;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      mc++;
      if (held) begin
        chk(rsp_valid && rsp_hit == h_hit && rsp_way == h_way && rsp_rdata == h_data,
            "R11", "response held under stall", rsp_rdata, h_data);
        held = 1'b0;
      end
      rsp_ready = (mc % 4) != 1;
      if (rst_n && rsp_valid && !rsp_ready) begin
        held = 1'b1; h_hit = rsp_hit; h_way = rsp_way; h_data = rsp_rdata;
      end
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) chk(1'b0, "R11", "unexpected response", 32'(rsp_hit), 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_hit == e.hit, e.rq, "rsp_hit", 32'(rsp_hit), 32'(e.hit));
          chk(rsp_way == e.way, e.rq, "rsp_way", 32'(rsp_way), 32'(e.way));
          chk(rsp_rdata == e.data, e.rq, "rsp_rdata", rsp_rdata, e.data);
        end
      end
    end
  end

  task automatic access(input bit wr, input bit cb, input int s, input int w,
                        input logic [18:0] tg, input logic [31:0] wd, input bit ehit,
                        input logic [1:0] eway, input logic [31:0] edata, input string rq);
    exp_t e;
    e.hit = ehit; e.way = eway; e.data = edata; e.rq = rq;
    sb.push_back(e);
    @(negedge clk);
    copyback = cb; req_write = wr; req_wdata = wd;
    req_vaddr = 32'((s << 5) | (w << 2));
    req_paddr = pa_of(tg, s, w);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int s, input int w, input logic [18:0] tg, input bit ehit,
                    input logic [1:0] eway, input string rq);
    access(1'b0, 1'b1, s, w, tg, 32'h0, ehit, eway, mem_at(tg, s, w), rq);
  endtask

  initial begin
    int m0, t0, b0;
    bit ok;
    copyback = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_vaddr = '0; req_paddr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !wb_valid && !mrd_valid && !fill_ready && !wt_valid,
        "R1", "idle outputs after reset", {26'd0, req_ready, rsp_valid, wb_valid,
        mrd_valid, fill_ready, wt_valid}, 32'h20);

    // R1/R3: first read misses and fills way 0
    rd(3, 2, 19'd1, 1'b0, 2'd0, "R1");
    chk(last_mrd_addr == {pa_of(19'd1, 3, 0)}, "R3", "fetch address",
        32'(last_mrd_addr), 32'(pa_of(19'd1, 3, 0)));
    chk(n_mrd == 1, "R3", "one fetch", n_mrd, 1);
    rd(3, 5, 19'd1, 1'b1, 2'd0, "R3");
    // R2: same tag, other set misses; hit reports selected word
    rd(4, 0, 19'd1, 1'b0, 2'd0, "R2");
    rd(3, 7, 19'd1, 1'b1, 2'd0, "R2");
    // R4: remaining invalid ways in ascending order
    rd(3, 0, 19'd2, 1'b0, 2'd1, "R4");
    rd(3, 0, 19'd3, 1'b0, 2'd2, "R4");
    rd(3, 0, 19'd4, 1'b0, 2'd3, "R4");
    // R5: true LRU
    rd(3, 1, 19'd1, 1'b1, 2'd0, "R5");
    rd(3, 0, 19'd5, 1'b0, 2'd1, "R5");
    rd(3, 0, 19'd3, 1'b1, 2'd2, "R5");
    rd(3, 0, 19'd6, 1'b0, 2'd3, "R5");
    // R6: copy-back write hit
    t0 = n_wt;
    access(1'b1, 1'b1, 3, 1, 19'd1, 32'hD1D1_0001, 1'b1, 2'd0, 32'hD1D1_0001, "R6");
    chk(n_wt == t0, "R6", "no write-through", n_wt, t0);
    access(1'b0, 1'b1, 3, 1, 19'd1, 32'h0, 1'b1, 2'd0, 32'hD1D1_0001, "R6");
    // R9: age ways 1..3, then dirty way 0 is evicted
    rd(3, 0, 19'd5, 1'b1, 2'd1, "R5");
    rd(3, 0, 19'd3, 1'b1, 2'd2, "R5");
    rd(3, 0, 19'd6, 1'b1, 2'd3, "R5");
    rd(3, 0, 19'd7, 1'b0, 2'd0, "R9");
    chk(wb_beats == 8, "R9", "write-back beats", wb_beats, 8);
    chk(wb_at_mrd == 8, "R9", "write-back before fetch", wb_at_mrd, 8);
    chk(wb_tag_seen == 19'd1, "R9", "wb_tag", 32'(wb_tag_seen), 1);
    chk(wb_set_seen == 6'd3, "R9", "wb_set", 32'(wb_set_seen), 3);
    chk(wb_last_ok, "R9", "wb_last only on beat 7", 32'(wb_last_ok), 1);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] ev;
      ev = (i == 1) ? 32'hD1D1_0001 : pat({19'd1, 5'd3, 3'(i)});
      if (wb_buf[i] !== ev) ok = 1'b0;
    end
    chk(ok, "R9", "write-back words", wb_buf[1], 32'hD1D1_0001);
    // R7: write-through hit
    t0 = n_wt;
    access(1'b1, 1'b0, 3, 3, 19'd7, 32'hCAFE_0007, 1'b1, 2'd0, 32'hCAFE_0007, "R7");
    chk(n_wt == t0 + 1, "R7", "one write-through", n_wt, t0 + 1);
    chk(last_wt_addr == pa_of(19'd7, 3, 3), "R7", "wt_addr",
        32'(last_wt_addr), 32'(pa_of(19'd7, 3, 3)));
    chk(last_wt_data == 32'hCAFE_0007, "R7", "wt_data", last_wt_data, 32'hCAFE_0007);
    access(1'b0, 1'b0, 3, 3, 19'd7, 32'h0, 1'b1, 2'd0, 32'hCAFE_0007, "R7");
    rd(3, 0, 19'd5, 1'b1, 2'd1, "R5");
    rd(3, 0, 19'd3, 1'b1, 2'd2, "R5");
    rd(3, 0, 19'd6, 1'b1, 2'd3, "R5");
    b0 = wb_beats;
    rd(3, 0, 19'd8, 1'b0, 2'd0, "R7");
    chk(wb_beats == b0, "R7", "clean eviction, no write-back", wb_beats, b0);
    // R8: write-through miss forwards, no allocation
    m0 = n_mrd; t0 = n_wt;
    access(1'b1, 1'b0, 3, 2, 19'd9, 32'hBEEF_0009, 1'b0, 2'd0, 32'hBEEF_0009, "R8");
    chk(n_mrd == m0, "R8", "no fetch", n_mrd, m0);
    chk(n_wt == t0 + 1, "R8", "write forwarded", n_wt, t0 + 1);
    access(1'b0, 1'b1, 3, 2, 19'd9, 32'h0, 1'b0, 2'd1, 32'hBEEF_0009, "R8");
    chk(n_mrd == m0 + 1, "R8", "line was not allocated", n_mrd, m0 + 1);
    // R10: copy-back write miss allocates and dirties
    m0 = n_mrd; t0 = n_wt;
    access(1'b1, 1'b1, 10, 4, 19'd2, 32'hA110_C8ED, 1'b0, 2'd0, 32'hA110_C8ED, "R10");
    chk(n_mrd == m0 + 1, "R10", "fetch issued", n_mrd, m0 + 1);
    chk(n_wt == t0, "R10", "no write-through", n_wt, t0);
    access(1'b0, 1'b1, 10, 4, 19'd2, 32'h0, 1'b1, 2'd0, 32'hA110_C8ED, "R10");

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule